// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block is a bank of general-purpose pins, 32 by default, sitting behind a small word-addressed register port. Each pin has a direction bit, an output latch and an input sample that has passed through a two-flop synchronizer. Software drives pins high or low by writing a mask to a set port or a clear port, so it never has to read, modify and write the latch. It reads back both the latch and the sampled pin levels.

Every pin can also act as an interrupt source. Four independent per-pin detect masks choose the condition: low level, high level, rising edge or falling edge. Setting both edge masks makes a pin fire on either edge. A detected condition latches a per-pin status bit, whatever the pin's direction and whatever its enable bit. Status bits are cleared by writing ones, and a level source whose level still holds sets its bit again. A single interrupt line is raised while any status bit whose enable bit is set is high. Enable bits have their own set and clear ports.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the direction register reads all ones, and the output latch, all four detect masks, the enable mask and the status register read zero. `pin_oe` is zero and `irq` is low.
- R2: A write to OUT_SET (address 2) sets the latch bits where the write data is 1, and a write to OUT_CLR (address 3) clears them. Zero data bits leave the latch unchanged. The latch drives `pin_out` and reads back at OUT (address 1).
- R3: DIR (address 0) is read-write. A 1 bit makes that pin an input and a 0 bit makes it an output. `pin_oe` is the bitwise inverse of DIR.
- R4: PIN_IN (address 4) returns `pin_in` through a two-flop synchronizer. A pin change driven before clock edge k reads back after edge k+1. A status bit triggered by that change becomes visible after edge k+2.
- R5: The detect masks are DET_LOW (5), DET_HIGH (6), DET_RISE (7) and DET_FALL (8). A pin with rise or fall set responds only to that edge. With both set it responds to either edge. Detection works on every pin, whatever its direction.
- R6: Writing a mask to IEN_SET (10) sets those enable bits, and writing a mask to IEN_CLR (11) clears them. Zero bits have no effect. The enable mask reads back at IEN (9).
- R7: Writing ones to STAT (12) clears those status bits when no detect condition is active on them. Zero data bits leave status unchanged.
- R8: A level source whose level is still active keeps its status bit set through a clear write. When a detect event and a clear write hit the same bit in the same cycle, the event wins.
- R9: An edge status bit stays latched until it is cleared. It is set even while its enable bit is clear, and `irq` rises as soon as that enable bit is set.
- R10: `irq` is high exactly when some bit is set in both the status register and the enable mask. STAT_EN (13) reads that bitwise AND.
- R11: The write-only addresses 2, 3, 10 and 11, and the unused addresses 14 and 15, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for `reg_addr`, same cycle |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable per pin, 1 drives the pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the bank with NPINS set to 8. That small width lets it sweep every pin through all five trigger modes: low level, high level, rising edge, falling edge and both edges. For each pin and mode it checks the status bit, the interrupt line, the masked status and the behaviour after a clear, against expectations derived from the mode. The narrow width also makes it practical to walk set and clear writes across every latch bit. It measures the exact synchronizer-plus-status latency in clock edges, and it runs directed cases for an edge latched while its enable is off and for reads of the write-only and unused addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR      = 4'd0,
        A_OUT      = 4'd1,
        A_OUT_SET  = 4'd2,
        A_OUT_CLR  = 4'd3,
        A_PIN_IN   = 4'd4,
        A_DET_LOW  = 4'd5,
        A_DET_HIGH = 4'd6,
        A_DET_RISE = 4'd7,
        A_DET_FALL = 4'd8,
        A_IEN      = 4'd9,
        A_IEN_SET  = 4'd10,
        A_IEN_CLR  = 4'd11,
        A_STAT     = 4'd12,
        A_STAT_EN  = 4'd13
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] smp,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;
    logic [W-1:0] smp_q;
    logic [W-1:0] prv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            smp_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= async_in;
            smp_q  <= meta_q;
            prv_q  <= smp_q;
        end
    end

    assign smp = smp_q;
    assign prv = prv_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] smp,
    input  logic [W-1:0] prv,
    input  logic [W-1:0] det_low,
    input  logic [W-1:0] det_high,
    input  logic [W-1:0] det_rise,
    input  logic [W-1:0] det_fall,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic lvl_lo, lvl_hi, edg_up, edg_dn;
        assign lvl_lo = det_low[i]  & ~smp[i];
        assign lvl_hi = det_high[i] &  smp[i];
        assign edg_up = det_rise[i] &  smp[i] & ~prv[i];
        assign edg_dn = det_fall[i] & ~smp[i] &  prv[i];
        assign hit[i] = lvl_lo | lvl_hi | edg_up | edg_dn;
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic [W-1:0]      smp,
    input  logic [W-1:0]      hit,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      dlo_q,
    output logic [W-1:0]      dhi_q,
    output logic [W-1:0]      dup_q,
    output logic [W-1:0]      ddn_q,
    output logic [W-1:0]      ien_q,
    output logic [W-1:0]      stat_q
);
    logic [W-1:0] stat_ack;

    assign stat_ack = (we && addr == A_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
            dup_q  <= '0;
            ddn_q  <= '0;
            ien_q  <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_ack) | hit;
            if (we) begin
                case (addr)
                    A_DIR:      dir_q <= wdata;
                    A_OUT_SET:  out_q <= out_q | wdata;
                    A_OUT_CLR:  out_q <= out_q & ~wdata;
                    A_DET_LOW:  dlo_q <= wdata;
                    A_DET_HIGH: dhi_q <= wdata;
                    A_DET_RISE: dup_q <= wdata;
                    A_DET_FALL: ddn_q <= wdata;
                    A_IEN_SET:  ien_q <= ien_q | wdata;
                    A_IEN_CLR:  ien_q <= ien_q & ~wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            A_DIR:      rdata = dir_q;
            A_OUT:      rdata = out_q;
            A_PIN_IN:   rdata = smp;
            A_DET_LOW:  rdata = dlo_q;
            A_DET_HIGH: rdata = dhi_q;
            A_DET_RISE: rdata = dup_q;
            A_DET_FALL: rdata = ddn_q;
            A_IEN:      rdata = ien_q;
            A_STAT:     rdata = stat_q;
            A_STAT_EN:  rdata = stat_q & ien_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] smp, prv, hit;
    logic [NPINS-1:0] dir_q, dlo_q, dhi_q, dup_q, ddn_q;
    logic [NPINS-1:0] ien_q, stat_q;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .smp      (smp),
        .prv      (prv)
    );

    gpio_detect #(.W(NPINS)) u_det (
        .smp      (smp),
        .prv      (prv),
        .det_low  (dlo_q),
        .det_high (dhi_q),
        .det_rise (dup_q),
        .det_fall (ddn_q),
        .hit      (hit)
    );

    gpio_regs #(.W(NPINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .smp    (smp),
        .hit    (hit),
        .out_q  (pin_out),
        .dir_q  (dir_q),
        .dlo_q  (dlo_q),
        .dhi_q  (dhi_q),
        .dup_q  (dup_q),
        .ddn_q  (ddn_q),
        .ien_q  (ien_q),
        .stat_q (stat_q)
    );

    assign pin_oe = ~dir_q;
    assign irq    = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      pin_out,
    input logic              irq,
    input logic [W-1:0]      stat_q,
    input logic [W-1:0]      ien_q
);
    // R2: set port raises every written bit of the latch
    a_r2_out_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_OUT_SET) |=> ((pin_out & $past(reg_wdata)) == $past(reg_wdata)));

    // R2: clear port lowers every written bit of the latch
    a_r2_out_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_OUT_CLR) |=> ((pin_out & $past(reg_wdata)) == '0));

    // R6: set-enable port raises the written enable bits
    a_r6_ien_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_IEN_SET) |=> ((ien_q & $past(reg_wdata)) == $past(reg_wdata)));

    // R9: without a status write, no status bit ever drops
    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R10: with no enable bit set the interrupt line stays low
    a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .stat_q    (stat_q),
    .ien_q     (ien_q)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
    import gpio_irq_pkg::*;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    addr;
    logic          we;
    logic [NP-1:0] wdata, rdata, pin_in, pin_out, pin_oe;
    logic          irq;
    int            checks = 0;
    int            fails  = 0;

    always #10 clk = ~clk;

    gpio_irq_bank #(.NPINS(NP)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [NP-1:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic clear_dets();
        wr(A_DET_LOW, '0);
        wr(A_DET_HIGH, '0);
        wr(A_DET_RISE, '0);
        wr(A_DET_FALL, '0);
    endtask

    // mode: 0 low, 1 high, 2 rise, 3 fall, 4 both edges
    task automatic sweep_mode(input int p, input int mode);
        logic          start;
        logic          lvl;
        logic [NP-1:0] bitm;
        bitm  = NP'(1) << p;
        start = (mode == 0 || mode == 3) ? 1'b1 : 1'b0;
        lvl   = (mode <= 1);
        clear_dets();
        pin_in = start ? '1 : '0;
        idle(4);
        wr(A_STAT, '1);
        case (mode)
            0: wr(A_DET_LOW, bitm);
            1: wr(A_DET_HIGH, bitm);
            2: wr(A_DET_RISE, bitm);
            3: wr(A_DET_FALL, bitm);
            default: begin wr(A_DET_RISE, bitm); wr(A_DET_FALL, bitm); end
        endcase
        idle(1);
        rdchk("R5 idle level no status", A_STAT, '0);
        wr(A_IEN_SET, bitm);
        pin_in[p] = ~start;
        idle(4);
        rdchk("R5 condition sets own bit only", A_STAT, bitm);
        check("R10 irq on enabled status", NP'(irq), NP'(1));
        rdchk("R10 masked status", A_STAT_EN, bitm);
        wr(A_STAT, bitm);
        idle(2);
        if (lvl) rdchk("R8 level re-asserts after clear", A_STAT, bitm);
        else     rdchk("R7 edge status cleared", A_STAT, '0);
        pin_in[p] = start;
        idle(4);
        if (mode == 4)     rdchk("R5 both edges fires on return", A_STAT, bitm);
        else if (lvl)      rdchk("R7 level bit held until cleared", A_STAT, bitm);
        else               rdchk("R5 opposite edge ignored", A_STAT, '0);
        wr(A_IEN_CLR, bitm);
        wr(A_STAT, '1);
        idle(2);
        rdchk("R7 clear after level ends", A_STAT, '0);
        check("R10 irq low after clear", NP'(irq), NP'(0));
    endtask

    initial begin
        int wd = 0;
        while (wd < 200000) begin
            @(posedge clk);
            wd++;
        end
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NP-1:0] exp_out;
        logic [NP-1:0] b3;
        rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; pin_in = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rdchk("R1 dir reset", A_DIR, '1);
        rdchk("R1 out reset", A_OUT, '0);
        rdchk("R1 ien reset", A_IEN, '0);
        rdchk("R1 stat reset", A_STAT, '0);
        rdchk("R1 det_low reset", A_DET_LOW, '0);
        rdchk("R1 det_rise reset", A_DET_RISE, '0);
        check("R1 pin_oe reset", pin_oe, '0);
        check("R1 irq reset", NP'(irq), '0);

        // R2 set and clear walk
        exp_out = '0;
        for (int p = 0; p < NP; p++) begin
            wr(A_OUT_SET, NP'(1) << p);
            exp_out |= NP'(1) << p;
            rdchk("R2 set accumulates", A_OUT, exp_out);
            check("R2 pin_out follows latch", pin_out, exp_out);
        end
        for (int p = 0; p < NP; p += 2) begin
            wr(A_OUT_CLR, NP'(1) << p);
            exp_out &= ~(NP'(1) << p);
            rdchk("R2 clear one bit", A_OUT, exp_out);
        end
        wr(A_OUT_SET, '0);
        rdchk("R2 zero set no effect", A_OUT, exp_out);
        wr(A_OUT_CLR, '0);
        rdchk("R2 zero clear no effect", A_OUT, exp_out);

        // R3 direction
        wr(A_DIR, 8'hA5);
        rdchk("R3 dir readback", A_DIR, 8'hA5);
        check("R3 pin_oe inverse", pin_oe, 8'h5A);

        // R11 write-only and unused reads
        rdchk("R11 out_set reads 0", A_OUT_SET, '0);
        rdchk("R11 out_clr reads 0", A_OUT_CLR, '0);
        rdchk("R11 ien_set reads 0", A_IEN_SET, '0);
        rdchk("R11 ien_clr reads 0", A_IEN_CLR, '0);
        rdchk("R11 addr14 reads 0", 4'd14, '0);
        rdchk("R11 addr15 reads 0", 4'd15, '0);

        // R6 enable set/clear
        wr(A_IEN_SET, 8'h0F);
        wr(A_IEN_SET, 8'h30);
        rdchk("R6 set accumulates", A_IEN, 8'h3F);
        wr(A_IEN_CLR, 8'h05);
        rdchk("R6 clear bits", A_IEN, 8'h3A);
        wr(A_IEN_CLR, '1);
        rdchk("R6 clear all", A_IEN, '0);

        // R4 exact latency on pin 0 rising
        pin_in = '0;
        wr(A_DET_RISE, 8'h01);
        idle(3);
        wr(A_STAT, '1);
        pin_in[0] = 1'b1;
        idle(1);
        rdchk("R4 one edge: not yet sampled", A_PIN_IN, 8'h00);
        idle(1);
        rdchk("R4 two edges: sampled", A_PIN_IN, 8'h01);
        rdchk("R4 two edges: status not yet", A_STAT, 8'h00);
        idle(1);
        rdchk("R4 three edges: status set", A_STAT, 8'h01);

        // R9 edge latched while disabled, irq on enable
        b3 = 8'h08;
        clear_dets();
        pin_in = '0;
        idle(4);
        wr(A_STAT, '1);
        wr(A_DET_RISE, b3);
        pin_in[3] = 1'b1;
        idle(4);
        pin_in[3] = 1'b0;
        idle(6);
        rdchk("R9 edge latched while disabled", A_STAT, b3);
        check("R9 irq low while disabled", NP'(irq), '0);
        rdchk("R10 masked status empty", A_STAT_EN, '0);
        wr(A_STAT, '0);
        rdchk("R7 zero write keeps status", A_STAT, b3);
        wr(A_IEN_SET, b3);
        check("R9 irq on enable", NP'(irq), NP'(1));
        wr(A_STAT, b3);
        check("R10 irq drops after clear", NP'(irq), '0);
        wr(A_IEN_CLR, '1);

        // R5/R7/R8/R10 sweep, half the pins driven as outputs
        wr(A_DIR, 8'h55);
        for (int p = 0; p < NP; p++)
            for (int m = 0; m < 5; m++)
                sweep_mode(p, m);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule